// File: doc/BRIEF.md
# Reconfiguration Request Qualifier

This block sits beside the configuration logic of a device that has already loaded its program. It watches two active-low request pins and decides when a full reconfiguration has to begin. The main request comes from the shared done/program pin. If that pin is tied low on the board, the reset pin carries the request instead. A request counts only when the watched pin falls and then stays low for longer than a minimum time. That time is set as a number of system clock cycles. A low pulse that ends early is thrown away.

When a request is accepted, the block issues a one-cycle clear request. Downstream logic uses it to erase configuration memory and sample the mode inputs again, in the same way as an aborted load. After that pulse the block ignores both pins until the configured flag has dropped and risen again. A status output shows that the reset pin is the active request source.

The controller is a five-state machine. ST_IDLE waits for the configured flag. ST_PRIMARY watches the done/program pin. ST_FALLBACK watches the reset pin. ST_FIRE issues the pulse. ST_SPENT waits for the configured flag to clear. The transitions are:
- arm-primary: ST_IDLE to ST_PRIMARY, when configured rises and the done/program pin is high.
- arm-fallback: ST_IDLE to ST_FALLBACK, when configured rises and the done/program pin is low.
- release: ST_FALLBACK to ST_PRIMARY, when the done/program pin goes high.
- accept: ST_PRIMARY or ST_FALLBACK to ST_FIRE, when the watched pin qualifies.
- retire: ST_FIRE to ST_SPENT.
- drop: any state to ST_IDLE, when configured is low.

Top module: `reprog_qualifier`

## Requirements
- R1: While rst_n is low, and afterwards until a request is accepted, clear_req is 0. fallback_sel is 0 while rst_n is low.
- R2: In primary mode, suppose done_prog_n is first sampled low at clock edge t0 and stays low through edge t(MIN_LOW_CYCLES). Then clear_req is 1 for the cycle that follows edge t(MIN_LOW_CYCLES+2), and is 0 after edge t(MIN_LOW_CYCLES+1).
- R3: A low pulse sampled at only MIN_LOW_CYCLES edges produces no clear_req. A later full-length low pulse still qualifies with the R2 timing.
- R4: While the done/program pin is the source (fallback_sel = 0), low pulses of any length on reset_pin_n produce no clear_req.
- R5: If done_prog_n is low when configured rises, fallback_sel is 1 after the first clock edge that samples configured high. reset_pin_n then qualifies with the same edge and timing rule as R2.
- R6: In fallback mode, fallback_sel returns to 0 after the third clock edge from the one that first samples done_prog_n high. From then on, done_prog_n qualifies by the R2 rule.
- R7: After a clear_req pulse, no further pulse occurs until configured has been low and then high again.
- R8: No clear_req is issued while configured is low. This includes the cycle where qualification completes at the same edge that samples configured low.
- R9: clear_req is never high for two consecutive cycles.
- R10: A low level that began before a pin became the watched source does not qualify. A new falling edge is required.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| done_prog_n | input | 1 | Asynchronous active-low done/program pin; primary request |
| reset_pin_n | input | 1 | Asynchronous active-low reset pin; fallback request |
| configured | input | 1 | High while the device holds a loaded configuration |
| clear_req | output | 1 | One-cycle request to clear configuration memory and re-sample mode inputs |
| fallback_sel | output | 1 | High while the reset pin is the active request source |

## Verification
Two events can fall in the same cycle: the low-time count reaching its limit, and the configured flag dropping. If both arrive together, the drop must win and no clear request may appear. The bench provokes this by holding done_prog_n low and releasing configured in the exact clock period in which qualification completes, so the next edge sees both at once. It judges the outcome by checking that clear_req stays low on that edge and later. It then checks that a later re-arm still accepts a full pulse.

// File: rtl/reprog_pkg.sv
package reprog_pkg;

    // Request pins handled by the block; index 0 is the primary source.
    localparam int NPIN    = 2;
    localparam int PIN_PRI = 0;
    localparam int PIN_ALT = 1;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PRIMARY  = 3'd1,
        ST_FALLBACK = 3'd2,
        ST_FIRE     = 3'd3,
        ST_SPENT    = 3'd4
    } rq_state_t;

endpackage

// File: rtl/reprog_sync2.sv
module reprog_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Pins idle high, so both stages reset to the inactive level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            stab_q <= '1;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;

endmodule

// File: rtl/reprog_low_timer.sv
module reprog_low_timer #(
    parameter int MIN_LOW = 301
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic lvl,
    output logic qual
);

    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW);
    localparam logic [CW-1:0] ONE   = CW'(1);

    logic          lvl_d;
    logic          fall;
    logic          run;
    logic [CW-1:0] cnt;
    logic          at_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_d <= 1'b1;
        else        lvl_d <= lvl;
    end

    assign fall     = lvl_d & ~lvl;
    assign at_limit = (cnt == LIMIT);

    // The count starts only on a falling edge seen while enabled.
    // A return to high before the limit drops the attempt.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (!en) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (fall) begin
            run <= 1'b1;
            cnt <= ONE;
        end else if (run) begin
            if (lvl || at_limit) begin
                run <= 1'b0;
                cnt <= '0;
            end else begin
                cnt <= cnt + ONE;
            end
        end
    end

    assign qual = en & run & ~lvl & at_limit;

endmodule

// File: rtl/reprog_ctrl.sv
module reprog_ctrl
    import reprog_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            configured,
    input  logic            pri_low,
    input  logic [NPIN-1:0] qual,
    output logic [NPIN-1:0] tmr_en,
    output logic            clear_req,
    output logic            fallback_sel
);

    rq_state_t state_q;
    rq_state_t state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (configured) state_nxt = pri_low ? ST_FALLBACK : ST_PRIMARY;
            end
            ST_PRIMARY: begin
                if (!configured)       state_nxt = ST_IDLE;
                else if (qual[PIN_PRI]) state_nxt = ST_FIRE;
            end
            ST_FALLBACK: begin
                if (!configured)        state_nxt = ST_IDLE;
                else if (qual[PIN_ALT]) state_nxt = ST_FIRE;
                else if (!pri_low)      state_nxt = ST_PRIMARY;
            end
            ST_FIRE: begin
                state_nxt = configured ? ST_SPENT : ST_IDLE;
            end
            ST_SPENT: begin
                if (!configured) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Only the watched pin's timer runs.
    always_comb begin
        tmr_en          = '0;
        tmr_en[PIN_PRI] = (state_q == ST_PRIMARY);
        tmr_en[PIN_ALT] = (state_q == ST_FALLBACK);
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clear_req    <= 1'b0;
            fallback_sel <= 1'b0;
        end else begin
            clear_req    <= (state_nxt == ST_FIRE);
            fallback_sel <= (state_nxt == ST_FALLBACK);
        end
    end

endmodule

// File: rtl/reprog_qualifier.sv
module reprog_qualifier
    import reprog_pkg::*;
#(
    parameter int MIN_LOW_CYCLES = 301
) (
    input  logic clk,
    input  logic rst_n,
    input  logic done_prog_n,
    input  logic reset_pin_n,
    input  logic configured,
    output logic clear_req,
    output logic fallback_sel
);

    logic [NPIN-1:0] pin_raw;
    logic [NPIN-1:0] pin_s;
    logic [NPIN-1:0] tmr_en;
    logic [NPIN-1:0] tmr_qual;

    always_comb begin
        pin_raw          = '1;
        pin_raw[PIN_PRI] = done_prog_n;
        pin_raw[PIN_ALT] = reset_pin_n;
    end

    reprog_sync2 #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (pin_s)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_tmr
        reprog_low_timer #(.MIN_LOW(MIN_LOW_CYCLES)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (tmr_en[g]),
            .lvl   (pin_s[g]),
            .qual  (tmr_qual[g])
        );
    end

    reprog_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .configured   (configured),
        .pri_low      (~pin_s[PIN_PRI]),
        .qual         (tmr_qual),
        .tmr_en       (tmr_en),
        .clear_req    (clear_req),
        .fallback_sel (fallback_sel)
    );

endmodule

// File: rtl/reprog_qualifier_chk.sv
module reprog_qualifier_chk (
    input logic clk,
    input logic rst_n,
    input logic configured,
    input logic clear_req,
    input logic fallback_sel
);

    // Set by a pulse, cleared once configured has been seen low.
    logic fired_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          fired_q <= 1'b0;
        else if (clear_req)  fired_q <= 1'b1;
        else if (!configured) fired_q <= 1'b0;
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!clear_req && !fallback_sel);
        end
    end

    // R9
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> !clear_req);

    // R8
    configured_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |-> $past(configured));

    // R7
    single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |-> !fired_q);

    // R5
    fallback_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fallback_sel |-> $past(configured));

endmodule

bind reprog_qualifier reprog_qualifier_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .configured   (configured),
    .clear_req    (clear_req),
    .fallback_sel (fallback_sel)
);

// File: tb/test_reprog_qualifier.sv
module test_reprog_qualifier;

    localparam int MIN = 301;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic done_prog_n = 1'b1;
    logic reset_pin_n = 1'b1;
    logic configured = 1'b0;
    logic clear_req;
    logic fallback_sel;

    int checks = 0;
    int failures = 0;
    int pulses = 0;

    always #10 clk = ~clk;

    reprog_qualifier #(.MIN_LOW_CYCLES(MIN)) i_reprog_qualifier (
        .clk          (clk),
        .rst_n        (rst_n),
        .done_prog_n  (done_prog_n),
        .reset_pin_n  (reset_pin_n),
        .configured   (configured),
        .clear_req    (clear_req),
        .fallback_sel (fallback_sel)
    );

    // Counts pulses; each is counted one edge after it appears.
    always @(posedge clk) if (clear_req) pulses++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic rearm(input logic dp);
        configured  = 1'b0;
        wait_edges(2);
        done_prog_n = dp;
        wait_edges(4);
        configured  = 1'b1;
        wait_edges(3);
    endtask

    // Low pulse with exact timing check; pin is the one chosen by sel.
    task automatic full_pulse(input string req, input bit use_alt);
        if (use_alt) reset_pin_n = 1'b0; else done_prog_n = 1'b0;
        wait_edges(MIN + 2);
        check({req, " before limit"}, clear_req, 0);
        wait_edges(1);
        check({req, " pulse"}, clear_req, 1);
        wait_edges(1);
        check("R9 single cycle", clear_req, 0);
        if (use_alt) reset_pin_n = 1'b1; else done_prog_n = 1'b1;
        wait_edges(4);
    endtask

    task automatic t_reset;
        wait_edges(3);
        check("R1 clear_req in reset", clear_req, 0);
        check("R1 fallback_sel in reset", fallback_sel, 0);
        rst_n = 1'b1;
        wait_edges(5);
        check("R1 clear_req idle", clear_req, 0);
    endtask

    task automatic t_short_then_full;
        int p0;
        rearm(1'b1);
        check("R6 primary source", fallback_sel, 0);
        p0 = pulses;
        done_prog_n = 1'b0;
        wait_edges(MIN);
        done_prog_n = 1'b1;
        wait_edges(MIN + 6);
        check("R3 short pulse ignored", pulses - p0, 0);
        full_pulse("R2", 1'b0);
        check("R2 one pulse total", pulses - p0, 1);
    endtask

    task automatic t_spent;
        int p0;
        p0 = pulses;
        done_prog_n = 1'b0;
        wait_edges(MIN + 10);
        done_prog_n = 1'b1;
        wait_edges(4);
        check("R7 no second pulse", pulses - p0, 0);
        rearm(1'b1);
        full_pulse("R7 after rearm", 1'b0);
    endtask

    task automatic t_alt_ignored;
        int p0;
        rearm(1'b1);
        p0 = pulses;
        reset_pin_n = 1'b0;
        wait_edges(MIN + 10);
        reset_pin_n = 1'b1;
        wait_edges(4);
        check("R4 reset pin ignored", pulses - p0, 0);
        check("R4 still primary", fallback_sel, 0);
    endtask

    task automatic t_race;
        int p0;
        rearm(1'b1);
        p0 = pulses;
        done_prog_n = 1'b0;
        wait_edges(MIN + 2);
        configured = 1'b0;
        wait_edges(1);
        check("R8 drop wins race", clear_req, 0);
        wait_edges(3);
        check("R8 no pulse after race", pulses - p0, 0);
        done_prog_n = 1'b1;
        wait_edges(4);
        done_prog_n = 1'b0;
        wait_edges(MIN + 10);
        done_prog_n = 1'b1;
        wait_edges(4);
        check("R8 unconfigured ignored", pulses - p0, 0);
        rearm(1'b1);
        full_pulse("R8 rearm", 1'b0);
    endtask

    task automatic t_fallback;
        int p0;
        configured  = 1'b0;
        wait_edges(2);
        done_prog_n = 1'b0;
        reset_pin_n = 1'b0;
        wait_edges(4);
        configured  = 1'b1;
        wait_edges(1);
        check("R5 fallback selected", fallback_sel, 1);
        p0 = pulses;
        wait_edges(MIN + 10);
        check("R10 old low ignored", pulses - p0, 0);
        reset_pin_n = 1'b1;
        wait_edges(4);
        full_pulse("R5 reset pin", 1'b1);
        check("R5 status after pulse", fallback_sel, 0);
        done_prog_n = 1'b1;
        wait_edges(4);
    endtask

    task automatic t_release;
        configured  = 1'b0;
        wait_edges(2);
        done_prog_n = 1'b0;
        wait_edges(4);
        configured  = 1'b1;
        wait_edges(3);
        check("R6 in fallback", fallback_sel, 1);
        done_prog_n = 1'b1;
        wait_edges(2);
        check("R6 before release", fallback_sel, 1);
        wait_edges(1);
        check("R6 released", fallback_sel, 0);
        wait_edges(3);
        full_pulse("R6 primary again", 1'b0);
    endtask

    initial begin
        t_reset();
        t_short_then_full();
        t_spent();
        t_alt_ignored();
        t_race();
        t_fallback();
        t_release();
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

endmodule